// File: doc/BRIEF.md
# Accumulator Processor with Hardwired Sequencer

This block is a compact multicycle processor built around a single accumulator. It talks to one shared synchronous memory through one port, and the same port serves instruction fetch, operand reads and result writes. Internally it keeps an accumulator, a program counter, an instruction register, a memory address register and a memory buffer register. A hardwired sequencer moves data between these registers one step at a time. Each memory access takes its own step, and read data comes back one cycle after the address is presented.

Every instruction word carries an opcode and an explicit operand address. The sequencer decodes the opcode into one-hot instruction lines and runs fetch, decode and execute in a loop until it reaches a halt. The instruction set has the usual load, store, add, subtract, jump and conditional skip. It also has an add through a pointer, a subroutine call that saves its return address in memory, and a single-step accumulator clear.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low and directly after reset, `halted` is 0 and `mem_we` is 0. The program counter starts at 0, so the first fetch reads address 0.
- R2: A word is split into opcode [15:12] and operand address X [11:0]. Opcode 1 loads M[X] into the accumulator. Opcode 2 writes the accumulator to M[X] with one `mem_we` pulse. Read data is taken one cycle after its address is on `mem_addr`.
- R3: Opcode 3 adds M[X] to the accumulator and opcode 4 subtracts it. Both wrap modulo 2^16.
- R4: Opcode B reads M[X] and uses its bits [11:0] as a second address P. It then reads M[P] and adds that value to the accumulator. M[X] is left unchanged.
- R5: Opcode 0 writes the return address (the call's address plus one, zero-extended) to M[X]. It then sets the accumulator to X+1 and continues execution at X+1.
- R6: Opcode A sets the accumulator to zero.
- R7: Opcode 8 skips the next instruction according to bits [11:10]. Code 00 skips when the accumulator is negative, 01 when it is zero, 10 when it is positive, and 11 never skips.
- R8: Opcode 9 continues execution at X. The program counter wraps from 4095 to 0.
- R9: Opcodes 5, 6 and C to F change nothing: no memory write and no accumulator change.
- R10: Opcode 7 raises `halted`, which then stays high with no further memory writes until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 16 | Data to be written |
| mem_we | output | 1 | Write strobe, one cycle per write |
| mem_rdata | input | 16 | Read data, valid one cycle after its address |
| halted | output | 1 | High once a halt has executed |

## Verification
The pointer add keeps a value at X that gives a different sum if it is added directly. A design that skips the second read therefore stores a wrong result. The subroutine test loads a non-zero accumulator before the call and stores the accumulator at the target. A design that saves the wrong return address, jumps to X instead of X+1, or keeps the old accumulator leaves the wrong words in memory. The skip tests cover all four condition codes with negative, zero and positive accumulators, using sentinel words that catch any store that should have been skipped. Another program reaches address 4095 and continues through the wrap to address 0. It also runs the no-op opcodes and counts the memory writes, so a stray write or a missing wrap shows up.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   // opcode numbers, used as indices into the one-hot decode lines
   localparam int OPC_CALL   = 0;
   localparam int OPC_LOAD   = 1;
   localparam int OPC_STORE  = 2;
   localparam int OPC_ADD    = 3;
   localparam int OPC_SUB    = 4;
   localparam int OPC_NOP_A  = 5;
   localparam int OPC_NOP_B  = 6;
   localparam int OPC_HALT   = 7;
   localparam int OPC_SKIP   = 8;
   localparam int OPC_JUMP   = 9;
   localparam int OPC_CLR    = 10;
   localparam int OPC_ADDIND = 11;

   typedef enum logic [4:0] {
      ST_FMAR, ST_FREQ, ST_FCAP, ST_FIR, ST_DEC,
      ST_OREQ, ST_OCAP, ST_IMAR, ST_IREQ, ST_ICAP, ST_EXE,
      ST_SMBR, ST_SWR,
      ST_CMAR, ST_CWR, ST_CMBR, ST_CONE, ST_CADD, ST_CPC,
      ST_HALT
   } step_e;

   typedef enum logic [1:0] {MAR_HOLD, MAR_PC, MAR_IR, MAR_MBR} mar_src_e;
   typedef enum logic [2:0] {MBR_HOLD, MBR_MEM, MBR_AC, MBR_PC, MBR_IR} mbr_src_e;
   typedef enum logic [2:0] {AC_HOLD, AC_ZERO, AC_ONE, AC_MBR, AC_ALU} ac_src_e;
   typedef enum logic [1:0] {PC_HOLD, PC_INC, PC_IR, PC_AC} pc_src_e;

   typedef struct packed {
      mar_src_e mar_src;
      mbr_src_e mbr_src;
      ac_src_e  ac_src;
      pc_src_e  pc_src;
      logic     alu_sub;
      logic     ir_ld;
      logic     mem_we;
   } ctl_t;

endpackage

// File: rtl/acc_opdec.sv
module acc_opdec #(
   parameter int OPC_W = 4
) (
   input  logic [OPC_W-1:0]      opc,
   output logic [(1<<OPC_W)-1:0] line
);
   localparam int NLINE = 1 << OPC_W;

   if (OPC_W < 1 || OPC_W > 6) begin : g_bad_width
      $error("acc_opdec: OPC_W out of range");
   end

   for (genvar i = 0; i < NLINE; i++) begin : g_line
      assign line[i] = (opc == OPC_W'(i));
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
   parameter int W     = 16,
   parameter int STYLE = 0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] y
);
   if (STYLE < 0 || STYLE > 1) begin : g_bad_style
      $error("acc_alu: STYLE must be 0 or 1");
   end

   if (STYLE == 0) begin : g_shared
      // one adder, operand inverted and carry injected for subtract
      logic [W-1:0] b_x;
      assign b_x = b ^ {W{sub}};
      assign y   = a + b_x + {{(W-1){1'b0}}, sub};
   end else begin : g_split
      // two independent paths, selected at the output
      logic [W-1:0] s_add;
      logic [W-1:0] s_sub;
      assign s_add = a + b;
      assign s_sub = a - b;
      assign y     = sub ? s_sub : s_add;
   end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int OPC_W     = 4,
   parameter int ALU_STYLE = 0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  ctl_t                       ctl,
   input  logic [DATA_W-1:0]          rd,
   output logic [OPC_W-1:0]           opcode,
   output logic [1:0]                 cond,
   output logic [DATA_W-OPC_W-1:0]    mar,
   output logic [DATA_W-1:0]          mbr,
   output logic [DATA_W-1:0]          ac,
   output logic [DATA_W-OPC_W-1:0]    pc,
   output logic                       ac_neg,
   output logic                       ac_zero
);
   localparam int ADDR_W = DATA_W - OPC_W;

   if (ADDR_W < 2) begin : g_bad_split
      $error("acc_datapath: address field too narrow");
   end

   logic [DATA_W-1:0] ir_q;
   logic [DATA_W-1:0] alu_y;
   logic [ADDR_W-1:0] x_addr;

   assign x_addr = ir_q[ADDR_W-1:0];
   assign opcode = ir_q[DATA_W-1 -: OPC_W];
   assign cond   = ir_q[ADDR_W-1 -: 2];

   acc_alu #(.W(DATA_W), .STYLE(ALU_STYLE)) u_alu (
      .a   (ac),
      .b   (mbr),
      .sub (ctl.alu_sub),
      .y   (alu_y)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mar <= '0;
      end else begin
         case (ctl.mar_src)
            MAR_PC:  mar <= pc;
            MAR_IR:  mar <= x_addr;
            MAR_MBR: mar <= mbr[ADDR_W-1:0];
            default: mar <= mar;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mbr <= '0;
      end else begin
         case (ctl.mbr_src)
            MBR_MEM: mbr <= rd;
            MBR_AC:  mbr <= ac;
            MBR_PC:  mbr <= DATA_W'(pc);
            MBR_IR:  mbr <= DATA_W'(x_addr);
            default: mbr <= mbr;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ac <= '0;
      end else begin
         case (ctl.ac_src)
            AC_ZERO: ac <= '0;
            AC_ONE:  ac <= DATA_W'(1);
            AC_MBR:  ac <= mbr;
            AC_ALU:  ac <= alu_y;
            default: ac <= ac;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc <= '0;
      end else begin
         case (ctl.pc_src)
            PC_INC:  pc <= pc + ADDR_W'(1);
            PC_IR:   pc <= x_addr;
            PC_AC:   pc <= ac[ADDR_W-1:0];
            default: pc <= pc;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ir_q <= '0;
      end else if (ctl.ir_ld) begin
         ir_q <= mbr;
      end
   end

   assign ac_neg  = ac[DATA_W-1];
   assign ac_zero = (ac == '0);

endmodule

// File: rtl/acc_seq.sv
module acc_seq
   import acc_cpu_pkg::*;
#(
   parameter int OPC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPC_W-1:0] opcode,
   input  logic [1:0]       cond,
   input  logic             ac_neg,
   input  logic             ac_zero,
   output ctl_t             ctl,
   output step_e            step,
   output logic             halted
);
   localparam int NLINE = 1 << OPC_W;

   logic [NLINE-1:0] line;
   step_e            nxt;
   logic             take_skip;
   logic             mem_op;
   logic             nop_any;

   acc_opdec #(.OPC_W(OPC_W)) u_dec (
      .opc  (opcode),
      .line (line)
   );

   assign mem_op  = line[OPC_LOAD] | line[OPC_ADD] | line[OPC_SUB] | line[OPC_ADDIND];
   assign nop_any = line[OPC_NOP_A] | line[OPC_NOP_B] | (|line[NLINE-1:OPC_ADDIND+1]);

   always_comb begin
      unique case (cond)
         2'b00:   take_skip = ac_neg;
         2'b01:   take_skip = ac_zero;
         2'b10:   take_skip = !ac_neg && !ac_zero;
         default: take_skip = 1'b0;
      endcase
   end

   always_comb begin
      ctl = '{mar_src: MAR_HOLD, mbr_src: MBR_HOLD, ac_src: AC_HOLD,
              pc_src: PC_HOLD, alu_sub: 1'b0, ir_ld: 1'b0, mem_we: 1'b0};
      nxt = step;
      case (step)
         ST_FMAR: begin ctl.mar_src = MAR_PC; nxt = ST_FREQ; end
         ST_FREQ: nxt = ST_FCAP;
         ST_FCAP: begin
            ctl.mbr_src = MBR_MEM;
            ctl.pc_src  = PC_INC;
            nxt         = ST_FIR;
         end
         ST_FIR:  begin ctl.ir_ld = 1'b1; nxt = ST_DEC; end
         ST_DEC: begin
            nxt = ST_FMAR;
            if (line[OPC_HALT]) begin
               nxt = ST_HALT;
            end else if (line[OPC_CLR]) begin
               ctl.ac_src = AC_ZERO;
            end else if (line[OPC_JUMP]) begin
               ctl.pc_src = PC_IR;
            end else if (line[OPC_SKIP]) begin
               if (take_skip) ctl.pc_src = PC_INC;
            end else if (line[OPC_CALL]) begin
               ctl.mbr_src = MBR_PC;
               nxt         = ST_CMAR;
            end else if (mem_op) begin
               ctl.mar_src = MAR_IR;
               nxt         = ST_OREQ;
            end else if (line[OPC_STORE]) begin
               ctl.mar_src = MAR_IR;
               nxt         = ST_SMBR;
            end else if (nop_any) begin
               nxt = ST_FMAR;
            end
         end
         ST_OREQ: nxt = ST_OCAP;
         ST_OCAP: begin
            ctl.mbr_src = MBR_MEM;
            nxt         = line[OPC_ADDIND] ? ST_IMAR : ST_EXE;
         end
         ST_IMAR: begin ctl.mar_src = MAR_MBR; nxt = ST_IREQ; end
         ST_IREQ: nxt = ST_ICAP;
         ST_ICAP: begin ctl.mbr_src = MBR_MEM; nxt = ST_EXE; end
         ST_EXE: begin
            if (line[OPC_LOAD]) begin
               ctl.ac_src = AC_MBR;
            end else begin
               ctl.ac_src  = AC_ALU;
               ctl.alu_sub = line[OPC_SUB];
            end
            nxt = ST_FMAR;
         end
         ST_SMBR: begin ctl.mbr_src = MBR_AC; nxt = ST_SWR; end
         ST_SWR:  begin ctl.mem_we = 1'b1; nxt = ST_FMAR; end
         ST_CMAR: begin ctl.mar_src = MAR_IR; nxt = ST_CWR; end
         ST_CWR:  begin ctl.mem_we = 1'b1; nxt = ST_CMBR; end
         ST_CMBR: begin ctl.mbr_src = MBR_IR; nxt = ST_CONE; end
         ST_CONE: begin ctl.ac_src = AC_ONE; nxt = ST_CADD; end
         ST_CADD: begin ctl.ac_src = AC_ALU; nxt = ST_CPC; end
         ST_CPC:  begin ctl.pc_src = PC_AC; nxt = ST_FMAR; end
         ST_HALT: nxt = ST_HALT;
         default: nxt = ST_FMAR;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step <= ST_FMAR;
      else        step <= nxt;
   end

   assign halted = (step == ST_HALT);

   // R10
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && !ctl.mem_we));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int OPC_W     = 4,
   parameter int ALU_STYLE = 0,
   localparam int ADDR_W   = DATA_W - OPC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              halted
);
   if (OPC_W != 4) begin : g_bad_opc
      $error("acc_cpu: the opcode map needs a 4-bit opcode");
   end
   if (DATA_W < OPC_W + 2) begin : g_bad_data
      $error("acc_cpu: DATA_W too small for the skip condition field");
   end

   ctl_t              ctl;
   step_e             step;
   logic [OPC_W-1:0]  opcode;
   logic [1:0]        cond;
   logic [DATA_W-1:0] mbr;
   logic [DATA_W-1:0] ac;
   logic [ADDR_W-1:0] pc;
   logic [ADDR_W-1:0] mar;
   logic              ac_neg;
   logic              ac_zero;

   acc_seq #(.OPC_W(OPC_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .opcode  (opcode),
      .cond    (cond),
      .ac_neg  (ac_neg),
      .ac_zero (ac_zero),
      .ctl     (ctl),
      .step    (step),
      .halted  (halted)
   );

   acc_datapath #(.DATA_W(DATA_W), .OPC_W(OPC_W), .ALU_STYLE(ALU_STYLE)) u_dp (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl     (ctl),
      .rd      (mem_rdata),
      .opcode  (opcode),
      .cond    (cond),
      .mar     (mar),
      .mbr     (mbr),
      .ac      (ac),
      .pc      (pc),
      .ac_neg  (ac_neg),
      .ac_zero (ac_zero)
   );

   assign mem_addr  = mar;
   assign mem_wdata = mbr;
   assign mem_we    = ctl.mem_we;

   // R2
   store_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && opcode == OPC_W'(OPC_STORE)) |-> (mem_wdata == ac));

   // R5
   call_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && opcode == OPC_W'(OPC_CALL)) |-> (mem_wdata == DATA_W'(pc)));

   // R5
   call_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step == ST_CPC) |=> (pc == ADDR_W'(mem_addr + ADDR_W'(1))));

   // R4
   ind_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step == ST_IREQ) |-> (mem_addr == mbr[ADDR_W-1:0]));

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |-> (!mem_we && !halted));

endmodule

// File: tb/acc_cpu_test.sv
`timescale 1ns/1ps
module acc_cpu_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] mem_addr;
   logic [15:0] mem_wdata;
   logic        mem_we;
   logic [15:0] mem_rdata;
   logic        halted;

   logic [15:0] mem [0:4095];
   logic        ld_clr = 1'b0;
   logic        ld_en = 1'b0;
   logic [11:0] ld_addr = '0;
   logic [15:0] ld_data = '0;
   int          wr_cnt = 0;
   int          total = 0;
   int          bad = 0;
   bit          finished = 1'b0;

   always #2.5 clk = ~clk;

   acc_cpu uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .mem_rdata (mem_rdata),
      .halted    (halted)
   );

   // synchronous memory with one cycle read latency
   always @(posedge clk) begin
      if (ld_clr) begin
         for (int i = 0; i < 4096; i++) mem[i] <= 16'h7000;
         wr_cnt <= 0;
      end else if (ld_en) begin
         mem[ld_addr] <= ld_data;
      end else if (mem_we) begin
         mem[mem_addr] <= mem_wdata;
         wr_cnt <= wr_cnt + 1;
      end
      mem_rdata <= mem[mem_addr];
   end

   function automatic logic [15:0] ins(input int op, input int x);
      return {op[3:0], x[11:0]};
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic begin_prog();
      @(negedge clk);
      rst_n  = 1'b0;
      ld_clr = 1'b1;
      @(negedge clk);
      ld_clr = 1'b0;
   endtask

   task automatic put(input int a, input logic [15:0] d);
      ld_en   = 1'b1;
      ld_addr = a[11:0];
      ld_data = d;
      @(negedge clk);
      ld_en   = 1'b0;
   endtask

   task automatic run_prog(input string req);
      bit done = 1'b0;
      rst_n = 1'b1;
      for (int c = 0; c < 3000; c++) begin
         @(negedge clk);
         if (halted) begin
            done = 1'b1;
            break;
         end
      end
      chk({req, " halt reached"}, {15'd0, done}, 16'd1);
   endtask

   task automatic t_reset();
      begin_prog();
      repeat (3) @(negedge clk);
      chk("R1 halted in reset", {15'd0, halted}, 16'd0);
      chk("R1 we in reset", {15'd0, mem_we}, 16'd0);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R1 first fetch address", {4'd0, mem_addr}, 16'd0);
      chk("R1 no write after reset", {15'd0, mem_we}, 16'd0);
   endtask

   task automatic t_arith();
      int w;
      begin_prog();
      put(16'h000, ins(1, 16'h020));
      put(16'h001, ins(3, 16'h021));
      put(16'h002, ins(4, 16'h022));
      put(16'h003, ins(2, 16'h030));
      put(16'h004, ins(3, 16'h023));
      put(16'h005, ins(2, 16'h031));
      put(16'h006, ins(7, 0));
      put(16'h020, 16'd1000);
      put(16'h021, 16'd234);
      put(16'h022, 16'd34);
      put(16'h023, 16'hFFFF);
      run_prog("R10");
      chk("R2/R3 load add sub store", mem[12'h030], 16'd1200);
      chk("R3 add wraps", mem[12'h031], 16'd1199);
      chk("R2 load leaves source", mem[12'h020], 16'd1000);
      w = wr_cnt;
      repeat (40) @(negedge clk);
      chk("R10 halted sticky", {15'd0, halted}, 16'd1);
      chk("R10 no writes after halt", 16'(wr_cnt), 16'(w));
   endtask

   task automatic t_indirect();
      begin_prog();
      put(16'h000, ins(1, 16'h040));
      put(16'h001, ins(11, 16'h041));
      put(16'h002, ins(2, 16'h050));
      put(16'h003, ins(7, 0));
      put(16'h040, 16'd5);
      put(16'h041, 16'h0045);
      put(16'h045, 16'd37);
      run_prog("R4");
      chk("R4 pointer add", mem[12'h050], 16'd42);
      chk("R4 pointer word kept", mem[12'h041], 16'h0045);
   endtask

   task automatic t_call();
      begin_prog();
      put(16'h000, ins(1, 16'h060));
      put(16'h001, ins(0, 16'h010));
      put(16'h010, 16'h0000);
      put(16'h011, ins(2, 16'h070));
      put(16'h012, ins(7, 0));
      put(16'h060, 16'd7);
      run_prog("R5");
      chk("R5 return address saved", mem[12'h010], 16'h0002);
      chk("R5 accumulator becomes X+1", mem[12'h070], 16'h0011);
   endtask

   task automatic t_clear_skip();
      begin_prog();
      put(16'h000, ins(1, 16'h080));
      put(16'h001, ins(10, 0));
      put(16'h002, ins(2, 16'h090));
      put(16'h003, ins(8, 16'h400));
      put(16'h004, ins(2, 16'h091));
      put(16'h005, ins(1, 16'h081));
      put(16'h006, ins(8, 16'h000));
      put(16'h007, ins(2, 16'h092));
      put(16'h008, ins(8, 16'h800));
      put(16'h009, ins(2, 16'h093));
      put(16'h00A, ins(8, 16'h400));
      put(16'h00B, ins(2, 16'h094));
      put(16'h00C, ins(1, 16'h080));
      put(16'h00D, ins(8, 16'h800));
      put(16'h00E, ins(2, 16'h095));
      put(16'h00F, ins(8, 16'hC00));
      put(16'h010, ins(2, 16'h096));
      put(16'h011, ins(7, 0));
      put(16'h080, 16'd5);
      put(16'h081, 16'hFFFD);
      for (int a = 16'h090; a <= 16'h096; a++) put(a, 16'hBEEF);
      run_prog("R7");
      chk("R6 clear", mem[12'h090], 16'h0000);
      chk("R7 zero skips", mem[12'h091], 16'hBEEF);
      chk("R7 negative skips", mem[12'h092], 16'hBEEF);
      chk("R7 positive test on negative", mem[12'h093], 16'hFFFD);
      chk("R7 zero test on nonzero", mem[12'h094], 16'hFFFD);
      chk("R7 positive skips", mem[12'h095], 16'hBEEF);
      chk("R7 code 11 never skips", mem[12'h096], 16'd5);
   endtask

   task automatic t_jump_nop();
      begin_prog();
      put(16'h000, ins(8, 16'h400));
      put(16'h001, ins(7, 0));
      put(16'h002, ins(9, 16'h020));
      put(16'h020, ins(1, 16'h0A0));
      put(16'h021, ins(5, 0));
      put(16'h022, ins(6, 16'h0BC));
      put(16'h023, ins(12, 16'h0BC));
      put(16'h024, ins(15, 16'h0BC));
      put(16'h025, ins(2, 16'h0B0));
      put(16'h026, ins(9, 16'hFFF));
      put(16'hFFF, ins(2, 16'h0B1));
      put(16'h0A0, 16'h1234);
      run_prog("R8");
      chk("R9 no-ops keep accumulator", mem[12'h0B0], 16'h1234);
      chk("R8 jump to 4095 then wrap", mem[12'h0B1], 16'h1234);
      chk("R9 no-op writes nothing", mem[12'h0BC], 16'h7000);
      chk("R9 total write count", 16'(wr_cnt), 16'd2);
      chk("R8 code at 0 unchanged", mem[12'h000], 16'h8400);
   endtask

   initial begin
      t_reset();
      t_arith();
      t_indirect();
      t_call();
      t_clear_skip();
      t_jump_nop();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule